// File: doc/BRIEF.md
# Display Refresh Address Generator

This block produces the refresh-memory address that a character-cell display controller uses to fetch each character cell. A 14-bit address register, shown in octal as 30000 to 37777, steps forward by one each time the controller fetches a character. During the update cycle at the end of a display page, the register is reloaded from two page-base bytes that arrive one after the other on the byte-wide refresh data bus. The two bytes are selected by fixed counts of the external character counter. The controller is expected to read the words at octal 37774 and 37775 at those counts.

The last usable word sits at octal 37677, just below the page-base words. Advancing from there takes the address to one of two wrap bases, chosen by a base-select jumper input. The block also registers a combined refresh write indication, formed from the CPU and external write requests.

Top module: `refresh_addr_gen`

## Requirements
- R1: A synchronous reset sets `raddr_o` to octal 30000 (hex 3000) and drives `ld_hi_o`, `ld_lo_o` and `ref_wr_o` low.
- R2: When no load occurs, each clock edge with `adv_i` high adds one to `raddr_o`, modulo 2^14. An edge with `adv_i` low leaves `raddr_o` unchanged.
- R3: An edge with `upd_i` high and `ccnt_i` equal to 10 (bit 0 low) copies `rdata_i[5:0]` into `raddr_o[13:8]` and keeps `raddr_o[7:0]`.
- R4: An edge with `upd_i` high and `ccnt_i` equal to 11 (bit 0 high) copies `rdata_i[7:0]` into `raddr_o[7:0]` and keeps `raddr_o[13:8]`.
- R5: On a load edge, `adv_i` has no effect. With `upd_i` low, or at any other count, no load happens.
- R6: `ld_hi_o` (after an R3 load) and `ld_lo_o` (after an R4 load) are each high for exactly the cycle that follows the load edge. They are never high together.
- R7: The seam rule applies on an edge with `adv_i` high, no load, and `raddr_o` at octal 37677. Seam detection requires `raddr_o[13:12]` to be 11. With `base_sel_i` low, the address becomes octal 30000, taking priority over the increment.
- R8: Under the same seam condition with `base_sel_i` high, the address becomes octal 34000 (hex 3800).
- R9: One cycle after each edge, `ref_wr_o` equals the OR of `cpu_wr_i` and `ext_wr_i` as sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (phase-1 refresh clock) |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Character-fetch advance strobe |
| ccnt_i | input | 4 | Character-counter value |
| upd_i | input | 1 | Update-cycle flag |
| rdata_i | input | 8 | Refresh data bus byte |
| base_sel_i | input | 1 | Base-select jumper (1 = octal 34000 base) |
| cpu_wr_i | input | 1 | CPU write request |
| ext_wr_i | input | 1 | External device write request |
| raddr_o | output | 14 | Refresh memory address |
| ld_hi_o | output | 1 | Upper-stage load indication |
| ld_lo_o | output | 1 | Lower-stage load indication |
| ref_wr_o | output | 1 | Registered refresh write indication |

## Verification
Several rules are checked by assertions on every cycle. These are the step-by-one and hold behaviour, both byte loads with their one-cycle indications, the mutual exclusion of those indications, the seam wrap to either base, the registered write indication, and the post-reset state.

Some behaviour only shows up in the bench scenarios. One example is a full two-byte reload that places the address just below the seam and then walks it across the seam with each jumper setting. Others are the silent roll from octal 37777 to zero, and advance strobes that land on load cycles. Random traffic mixes counts and update flags so that near-miss counts exercise R5.

// File: rtl/refresh_addr_gen_pkg.sv
package refresh_addr_gen_pkg;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ld_hi;
        logic              ld_lo;
        logic              ref_wr;
    } rag_state_t;
endpackage

// File: rtl/rag_load_decode.sv
module rag_load_decode #(
    parameter int CNT_W  = 4,
    parameter int HI_CNT = 10
) (
    input  logic [CNT_W-1:0] ccnt_i,
    input  logic             upd_i,
    output logic             ld_hi_o,
    output logic             ld_lo_o
);
    localparam logic [CNT_W-1:0] HI_VAL = CNT_W'(HI_CNT);

    logic pair_match;

    // The two counts differ only in bit 0; bit 0 then chooses the stage.
    always_comb begin
        pair_match = upd_i && (ccnt_i[CNT_W-1:1] == HI_VAL[CNT_W-1:1]);
        ld_hi_o    = pair_match && !ccnt_i[0];
        ld_lo_o    = pair_match &&  ccnt_i[0];
    end
endmodule

// File: rtl/rag_seam_detect.sv
module rag_seam_detect #(
    parameter int               ADDR_W    = 14,
    parameter logic [ADDR_W-1:0] SEAM_ADDR = 14'o37677
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              seam_o
);
    logic top_en;

    // Detection is armed only while the top stage holds its top-of-memory value.
    always_comb begin
        top_en = (addr_i[ADDR_W-1:ADDR_W-2] == 2'b11);
        seam_o = top_en && (addr_i == SEAM_ADDR);
    end
endmodule

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen
    import refresh_addr_gen_pkg::*;
#(
    parameter int                HI_CNT    = 10,
    parameter logic [ADDR_W-1:0] SEAM_ADDR = 14'o37677,
    parameter logic [ADDR_W-1:0] BASE_LO   = 14'o30000,
    parameter logic [ADDR_W-1:0] BASE_HI   = 14'o34000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic [CNT_W-1:0]  ccnt_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              base_sel_i,
    input  logic              cpu_wr_i,
    input  logic              ext_wr_i,
    output logic [ADDR_W-1:0] raddr_o,
    output logic              ld_hi_o,
    output logic              ld_lo_o,
    output logic              ref_wr_o
);
    localparam int HI_W = ADDR_W - DATA_W;

    rag_state_t st_d, st_q;
    logic       ld_hi, ld_lo, seam;

    rag_load_decode #(.CNT_W(CNT_W), .HI_CNT(HI_CNT)) u_dec (
        .ccnt_i (ccnt_i),
        .upd_i  (upd_i),
        .ld_hi_o(ld_hi),
        .ld_lo_o(ld_lo)
    );

    rag_seam_detect #(.ADDR_W(ADDR_W), .SEAM_ADDR(SEAM_ADDR)) u_seam (
        .addr_i(st_q.addr),
        .seam_o(seam)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ld_hi  = ld_hi;
        st_d.ld_lo  = ld_lo;
        st_d.ref_wr = cpu_wr_i | ext_wr_i;
        if (ld_hi) begin
            st_d.addr[ADDR_W-1:DATA_W] = rdata_i[HI_W-1:0];
        end else if (ld_lo) begin
            st_d.addr[DATA_W-1:0] = rdata_i;
        end else if (adv_i) begin
            if (seam) st_d.addr = base_sel_i ? BASE_HI : BASE_LO;
            else      st_d.addr = st_q.addr + 1'b1;
        end
        if (rst) begin
            st_d.addr   = BASE_LO;
            st_d.ld_hi  = 1'b0;
            st_d.ld_lo  = 1'b0;
            st_d.ref_wr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign raddr_o  = st_q.addr;
    assign ld_hi_o  = st_q.ld_hi;
    assign ld_lo_o  = st_q.ld_lo;
    assign ref_wr_o = st_q.ref_wr;
endmodule

// File: rtl/refresh_addr_gen_checker.sv
module refresh_addr_gen_checker (
    input logic        clk,
    input logic        rst,
    input logic        adv_i,
    input logic [3:0]  ccnt_i,
    input logic        upd_i,
    input logic [7:0]  rdata_i,
    input logic        base_sel_i,
    input logic        cpu_wr_i,
    input logic        ext_wr_i,
    input logic [13:0] raddr_o,
    input logic        ld_hi_o,
    input logic        ld_lo_o,
    input logic        ref_wr_o
);
    logic any_load;
    assign any_load = upd_i && (ccnt_i == 4'd10 || ccnt_i == 4'd11);

    assert_reset_state_R1: assert property (@(posedge clk)
        $fell(rst) |-> (raddr_o == 14'o30000 && !ld_hi_o && !ld_lo_o && !ref_wr_o));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !any_load && raddr_o != 14'o37677) |=> raddr_o == $past(raddr_o) + 14'd1);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !any_load) |=> $stable(raddr_o));

    assert_hi_load_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_i && ccnt_i == 4'd10) |=> (raddr_o[13:8] == $past(rdata_i[5:0])
                                        && raddr_o[7:0] == $past(raddr_o[7:0])));

    assert_lo_load_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_i && ccnt_i == 4'd11) |=> (raddr_o[7:0] == $past(rdata_i)
                                        && raddr_o[13:8] == $past(raddr_o[13:8])));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_hi_o, ld_lo_o}));

    assert_strobe_hi_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_i && ccnt_i == 4'd10) |=> ld_hi_o);

    assert_strobe_none_R6: assert property (@(posedge clk) disable iff (rst)
        !any_load |=> (!ld_hi_o && !ld_lo_o));

    assert_seam_lo_R7: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !any_load && raddr_o == 14'o37677 && !base_sel_i) |=> raddr_o == 14'o30000);

    assert_seam_hi_R8: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !any_load && raddr_o == 14'o37677 && base_sel_i) |=> raddr_o == 14'o34000);

    assert_wr_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ref_wr_o == ($past(cpu_wr_i) | $past(ext_wr_i)));
endmodule

bind refresh_addr_gen refresh_addr_gen_checker u_chk (.*);

// File: tb/refresh_addr_gen_bench.sv
module refresh_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst, adv, upd, bsel, cpu_wr, ext_wr;
    logic [3:0]  ccnt;
    logic [7:0]  rdata;
    logic [13:0] raddr;
    logic        ld_hi, ld_lo, ref_wr;

    logic [13:0] e_addr;
    logic        e_hi, e_lo, e_wr;
    int          n_run = 0, n_fail = 0;
    int unsigned seed_v = 32'd1234;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    refresh_addr_gen u_refresh_addr_gen (
        .clk(clk), .rst(rst), .adv_i(adv), .ccnt_i(ccnt), .upd_i(upd),
        .rdata_i(rdata), .base_sel_i(bsel), .cpu_wr_i(cpu_wr), .ext_wr_i(ext_wr),
        .raddr_o(raddr), .ld_hi_o(ld_hi), .ld_lo_o(ld_lo), .ref_wr_o(ref_wr)
    );

    // Next address from the requirement text: load, then seam, then step.
    function automatic logic [13:0] next_addr(logic [13:0] a, logic av, logic up,
                                              logic [3:0] c, logic [7:0] d, logic bs);
        if (up && c == 4'd10) return {d[5:0], a[7:0]};
        if (up && c == 4'd11) return {a[13:8], d};
        if (!av) return a;
        if (a == 14'o37677) return bs ? 14'o34000 : 14'o30000;
        return a + 14'd1;
    endfunction

    task automatic check(string req);
        n_run++;
        if (raddr !== e_addr || ld_hi !== e_hi || ld_lo !== e_lo || ref_wr !== e_wr) begin
            n_fail++;
            $display("FAIL %s: got addr=%o hi=%b lo=%b wr=%b, expected addr=%o hi=%b lo=%b wr=%b",
                     req, raddr, ld_hi, ld_lo, ref_wr, e_addr, e_hi, e_lo, e_wr);
        end
    endtask

    // Drive at negedge, model at posedge, compare at the following negedge.
    task automatic step(logic av, logic up, logic [3:0] c, logic [7:0] d,
                        logic bs, logic cw, logic ew, string req);
        adv = av; upd = up; ccnt = c; rdata = d; bsel = bs; cpu_wr = cw; ext_wr = ew;
        @(posedge clk);
        e_addr = next_addr(e_addr, av, up, c, d, bs);
        e_hi   = up && c == 4'd10;
        e_lo   = up && c == 4'd11;
        e_wr   = cw | ew;
        @(negedge clk);
        check(req);
    endtask

    task automatic load_base(logic [7:0] hi, logic [7:0] lo);
        step(1'b1, 1'b1, 4'd10, hi, 1'b0, 1'b0, 1'b0, "R3 upper load, R5 advance ignored");
        step(1'b1, 1'b1, 4'd11, lo, 1'b0, 1'b0, 1'b0, "R4 lower load, R6 strobe");
    endtask

    initial begin
        rst = 1'b1; adv = 1'b0; upd = 1'b0; ccnt = 4'd0; rdata = 8'd0;
        bsel = 1'b0; cpu_wr = 1'b1; ext_wr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        e_addr = 14'o30000; e_hi = 1'b0; e_lo = 1'b0; e_wr = 1'b0;
        check("R1 reset state");
        rst = 1'b0;

        step(1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R2 step");
        step(1'b0, 1'b0, 4'd3, 8'hFF, 1'b0, 1'b0, 1'b0, "R2 hold");
        step(1'b1, 1'b0, 4'd10, 8'h3A, 1'b0, 1'b0, 1'b0, "R5 count 10 without update");
        step(1'b0, 1'b1, 4'd12, 8'h3A, 1'b0, 1'b0, 1'b0, "R5 other count in update");
        // Place the address just below the seam, then cross it with jumper low.
        load_base(8'h3F, 8'hBD);
        step(1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R2 step to 37676");
        step(1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R2 step to seam");
        step(1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R7 seam wrap low base");
        // Same crossing with jumper high.
        load_base(8'h3F, 8'hBF);
        step(1'b1, 1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R8 seam wrap high base");
        // Seam value reached but no advance: must hold.
        load_base(8'h3F, 8'hBF);
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R2 hold at seam");
        // Above the seam, counting rolls over to zero.
        load_base(8'hFF, 8'hFF);
        step(1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R2 modulo roll to zero");
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, "R9 external write");
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, 1'b0, "R9 cpu write");
        step(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R9 no write");

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] c;
            logic [7:0] d;
            c = ($urandom(seed_v) % 4 == 0) ? 4'(10 + $urandom % 2) : 4'($urandom % 16);
            d = 8'($urandom % 256);
            if ($urandom % 8 == 0) d[5:0] = 6'h3F;
            step(1'($urandom % 2), ($urandom % 3 == 0), c, d, 1'($urandom % 2),
                 1'($urandom % 2), 1'($urandom % 2), "R2 R3 R4 R5 R6 R7 R8 R9 random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule